// File: doc/BRIEF.md
# Clock Ratio Change Sequencer

This block owns the clock ratio settings of a processor subsystem. Software writes a control word with three code fields: a PLL multiplier code, a core clock divider code and a peripheral clock divider code. The block drives these as its active ratio codes. It does not generate any clock itself; downstream clock logic reads the codes.

A write that changes only the divider codes takes effect on the next cycle. A write that changes the multiplier code works differently. It stalls the core and starts an 8-bit up-counter from a value that software loaded earlier. While that wait lasts, the block can also close the core and peripheral clock gates. When the counter wraps from all-ones to zero, the block applies the new codes together, opens the gates and releases the core. Software picks the wait length with two values: the preload count and a prescale select that slows the counter's tick.

Ratio and timer writes are dropped while a wait is in progress. A field code outside its legal set leaves that field unchanged and sets a sticky error flag. The block also raises a one-cycle hazard indication for a divider-only change that is risky while a DMA transfer is in progress.

Top module: `clk_ratio_seq`

## Requirements
- R1: After reset the multiplier code is 000, the core divider code is 000, the peripheral divider code is 010, busy, stall and counter-running are low, the counter reads 0, the error flag is low and both clock gates are open (1).
- R2: A write with `wr_sel`=01 while idle loads the counter from `wr_data[7:0]` and the prescale select from `wr_data[10:8]`. The counter does not start running.
- R3: A ratio write (`wr_sel`=00; core divider in `wr_data[2:0]`, peripheral divider in `[5:3]`, multiplier in `[8:6]`) whose legal multiplier code differs from the active one raises busy, stall and counter-running from the next cycle. The counter then steps by one every 2^(n+1) clocks, where n is the prescale select.
- R4: While busy, both clock gates are 0 when `clk_mode` is 0, 1, 2 or 7, and 1 for any other mode. When the block is not busy, both gates are 1.
- R5: The busy period lasts exactly (256 − preload) × 2^(n+1) cycles. On the cycle it ends, the pending multiplier and divider codes appear together, busy, stall and running drop, and the counter reads 0.
- R6: The active codes do not change while busy.
- R7: A ratio write that leaves the multiplier code unchanged applies its divider codes on the next cycle, and the counter is not started.
- R8: Ratio and timer writes made while busy have no effect.
- R9: The legal multiplier codes are 000, 001 and 011. The legal divider codes are 000 to 100. An illegal code in a field keeps that field's previous value and sets the error flag.
- R10: Writing `wr_sel`=10 with `wr_data[0]`=1 clears the error flag. If `wr_data[0]` is 0, the flag is left as it is.
- R11: `hazard` is high for one cycle after a divider-only ratio write in which the core divider code changes and the new core divider code differs from the new peripheral divider code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_mode | input | 3 | Board clock mode; selects whether the clocks are gated during a wait |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 00 ratio, 01 timer, 10 error clear |
| wr_data | input | 16 | Write data |
| mul_code | output | 3 | Active multiplier code |
| core_div | output | 3 | Active core divider code |
| per_div | output | 3 | Active peripheral divider code |
| core_stall | output | 1 | Core halted during the settling wait |
| core_clk_en | output | 1 | Core clock gate |
| per_clk_en | output | 1 | Peripheral clock gate |
| cnt_running | output | 1 | Settling counter is running |
| settle_cnt | output | 8 | Settling counter value |
| busy | output | 1 | Wait in progress; writes are dropped |
| cfg_err | output | 1 | Sticky illegal-code flag |
| hazard | output | 1 | One-cycle hazard indication for a divider-only change |

## Verification
Suppose the prescale phase is off by one, or the counter steps on the wrong tick. Then `settle_cnt` shows a different value within 2^(n+1) cycles, and the release moves by whole tick periods, so busy and the ratio codes change on the wrong cycle. If a wait is missed, a divider-only change starts the counter by mistake, or a write made during a wait gets through, the ratio codes or the busy flag differ on the very next cycle. A reference model checks every output on every clock, so any such fault shows up in the cycle it first affects.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  localparam int unsigned CODE_W = 3;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    code_t mul;
    code_t cdiv;
    code_t pdiv;
  } ratio_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SETTLE = 1'b1
  } seq_state_e;

  localparam logic [1:0] SEL_RATIO = 2'b00;
  localparam logic [1:0] SEL_TIMER = 2'b01;
  localparam logic [1:0] SEL_CLEAR = 2'b10;

  localparam code_t MUL_RESET  = 3'b000;
  localparam code_t CDIV_RESET = 3'b000;
  localparam code_t PDIV_RESET = 3'b010;

  function automatic logic mul_legal(code_t c);
    return (c == 3'b000) || (c == 3'b001) || (c == 3'b011);
  endfunction

  function automatic logic div_legal(code_t c);
    return c <= 3'b100;
  endfunction

endpackage

// File: rtl/clkseq_rst_sync.sv
module clkseq_rst_sync (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/clkseq_field_filter.sv
module clkseq_field_filter
  import clkseq_pkg::*;
#(
  parameter bit IS_MUL = 1'b0
) (
  input  code_t wr_code,
  input  code_t cur_code,
  output code_t use_code,
  output logic  bad
);
  always_comb begin
    bad      = IS_MUL ? !mul_legal(wr_code) : !div_legal(wr_code);
    use_code = bad ? cur_code : wr_code;
  end
endmodule

// File: rtl/clkseq_settle_timer.sv
module clkseq_settle_timer #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [PSC_W-1:0] load_psc,
  input  logic             start,
  output logic             running,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam int unsigned PRE_W = 1 << PSC_W;

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] pre_lim;
  logic             tick;

  always_comb begin
    pre_lim = {PRE_W{1'b1}} >> (PSC_W'(PRE_W - 1) - psc_q);
    tick    = run_q && (pre_q == pre_lim);
    ovf     = tick && (cnt_q == {CNT_W{1'b1}});
  end

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    psc_d = psc_q;
    pre_d = pre_q;
    if (start) begin
      run_d = 1'b1;
      pre_d = '0;
    end else if (run_q) begin
      if (tick) begin
        pre_d = '0;
        cnt_d = cnt_q + 1'b1;
        if (ovf) run_d = 1'b0;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end else if (load_en) begin
      cnt_d = load_cnt;
      psc_d = load_psc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      psc_q <= '0;
      pre_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      psc_q <= psc_d;
      pre_q <= pre_d;
    end
  end

  assign running = run_q;
  assign cnt     = cnt_q;

  // R7: the counter never starts on its own
  p_idle_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> !run_q);

  // R5: overflow wraps to zero and stops
  p_wrap_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == '0 && !run_q));

  // R3: the count only moves on a prescaler tick
  p_step_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/clk_ratio_seq.sv
module clk_ratio_seq
  import clkseq_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned PSC_W      = 3,
  parameter int unsigned DATA_W     = 16,
  parameter logic [7:0]  GATE_MODES = 8'b1000_0111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        clk_mode,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [2:0]        mul_code,
  output logic [2:0]        core_div,
  output logic [2:0]        per_div,
  output logic              core_stall,
  output logic              core_clk_en,
  output logic              per_clk_en,
  output logic              cnt_running,
  output logic [CNT_W-1:0]  settle_cnt,
  output logic              busy,
  output logic              cfg_err,
  output logic              hazard
);
  localparam int unsigned NFIELD  = 3;
  localparam int unsigned PSC_LSB = CNT_W;

  logic       rst_sn;
  seq_state_e st_q, st_d;
  ratio_t     act_q, act_d, pend_q, pend_d, cand;
  logic       err_q, err_d, haz_q, haz_d;
  code_t      wr_f  [NFIELD];
  code_t      cur_f [NFIELD];
  code_t      use_f [NFIELD];
  logic       bad_f [NFIELD];
  logic       idle, wr_ratio, wr_timer, wr_clear, mul_chg, any_bad;
  logic       tmr_running, tmr_ovf, gate_mode;
  logic [CNT_W-1:0] tmr_cnt;

  clkseq_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_sn)
  );

  // field order: 0 core divider, 1 peripheral divider, 2 multiplier
  assign cur_f[0] = act_q.cdiv;
  assign cur_f[1] = act_q.pdiv;
  assign cur_f[2] = act_q.mul;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    assign wr_f[g] = wr_data[g*CODE_W +: CODE_W];
    clkseq_field_filter #(.IS_MUL(g == NFIELD - 1)) u_filter (
      .wr_code  (wr_f[g]),
      .cur_code (cur_f[g]),
      .use_code (use_f[g]),
      .bad      (bad_f[g])
    );
  end

  always_comb begin
    idle      = (st_q == ST_IDLE);
    wr_ratio  = wr_en && (wr_sel == SEL_RATIO) && idle;
    wr_timer  = wr_en && (wr_sel == SEL_TIMER) && idle;
    wr_clear  = wr_en && (wr_sel == SEL_CLEAR) && wr_data[0];
    any_bad   = bad_f[0] || bad_f[1] || bad_f[2];
    cand.mul  = use_f[2];
    cand.cdiv = use_f[0];
    cand.pdiv = use_f[1];
    mul_chg   = wr_ratio && (cand.mul != act_q.mul);
    gate_mode = GATE_MODES[clk_mode];
  end

  clkseq_settle_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sn),
    .load_en  (wr_timer),
    .load_cnt (wr_data[CNT_W-1:0]),
    .load_psc (wr_data[PSC_LSB +: PSC_W]),
    .start    (mul_chg),
    .running  (tmr_running),
    .cnt      (tmr_cnt),
    .ovf      (tmr_ovf)
  );

  always_comb begin
    st_d   = st_q;
    act_d  = act_q;
    pend_d = pend_q;
    err_d  = err_q;
    haz_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (mul_chg) begin
          st_d   = ST_SETTLE;
          pend_d = cand;
        end else if (wr_ratio) begin
          act_d = cand;
          haz_d = (cand.cdiv != act_q.cdiv) && (cand.cdiv != cand.pdiv);
        end
      end
      ST_SETTLE: begin
        if (tmr_ovf) begin
          st_d  = ST_IDLE;
          act_d = pend_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (wr_ratio && any_bad) err_d = 1'b1;
    else if (wr_clear)       err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      act_q  <= '{mul: MUL_RESET, cdiv: CDIV_RESET, pdiv: PDIV_RESET};
      pend_q <= '{mul: MUL_RESET, cdiv: CDIV_RESET, pdiv: PDIV_RESET};
      err_q  <= 1'b0;
      haz_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      act_q  <= act_d;
      pend_q <= pend_d;
      err_q  <= err_d;
      haz_q  <= haz_d;
    end
  end

  assign mul_code    = act_q.mul;
  assign core_div    = act_q.cdiv;
  assign per_div     = act_q.pdiv;
  assign busy        = (st_q == ST_SETTLE);
  assign core_stall  = (st_q == ST_SETTLE);
  assign core_clk_en = !((st_q == ST_SETTLE) && gate_mode);
  assign per_clk_en  = !((st_q == ST_SETTLE) && gate_mode);
  assign cnt_running = tmr_running;
  assign settle_cnt  = tmr_cnt;
  assign cfg_err     = err_q;
  assign hazard      = haz_q;

  // R3: sequencer state and timer run flag agree
  p_run_matches_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_SETTLE) == tmr_running);

  // R4: gates open whenever no wait is in progress
  p_gates_open_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_IDLE) |-> (core_clk_en && per_clk_en));

  // R6: active codes frozen across a wait
  p_hold_ratio_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_SETTLE && $past(st_q == ST_SETTLE)) |-> (act_q == $past(act_q)));

  // R5: the wait ends only at counter overflow
  p_settle_until_ovf_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_SETTLE && !tmr_ovf) |=> (st_q == ST_SETTLE));

  // R9: only legal codes ever reach the outputs
  p_legal_out_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    mul_legal(act_q.mul) && div_legal(act_q.cdiv) && div_legal(act_q.pdiv));
endmodule

// File: tb/test_clk_ratio_seq.sv
module test_clk_ratio_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  clk_mode;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic [2:0]  mul_code, core_div, per_div;
  logic        core_stall, core_clk_en, per_clk_en, cnt_running, busy, cfg_err, hazard;
  logic [7:0]  settle_cnt;

  always #5 clk = ~clk;

  clk_ratio_seq i_clk_ratio_seq (
    .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .mul_code(mul_code), .core_div(core_div), .per_div(per_div),
    .core_stall(core_stall), .core_clk_en(core_clk_en), .per_clk_en(per_clk_en),
    .cnt_running(cnt_running), .settle_cnt(settle_cnt), .busy(busy),
    .cfg_err(cfg_err), .hazard(hazard)
  );

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  int e_mul = 0, e_cd = 0, e_pd = 2;
  int e_busy = 0, e_err = 0, e_haz = 0;
  int e_cval = 0, e_psc = 0, e_el = 0;
  int p_mul = 0, p_cd = 0, p_pd = 0;

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int wait_len();
    return (256 - e_cval) * (2 ** (e_psc + 1));
  endfunction

  task automatic model_step();
    int nc, np, nm, cc, cp, cm;
    e_haz = 0;
    if (e_busy != 0) begin
      e_el++;
      if (e_el == wait_len()) begin
        e_mul = p_mul; e_cd = p_cd; e_pd = p_pd;
        e_busy = 0; e_cval = 0; e_el = 0;
      end
    end else if (wr_en) begin
      if (wr_sel == 2'b00) begin
        nc = int'(wr_data[2:0]); np = int'(wr_data[5:3]); nm = int'(wr_data[8:6]);
        cc = (nc <= 4) ? nc : e_cd;
        cp = (np <= 4) ? np : e_pd;
        cm = (nm == 0 || nm == 1 || nm == 3) ? nm : e_mul;
        if (nc > 4 || np > 4 || !(nm == 0 || nm == 1 || nm == 3)) e_err = 1;
        if (cm != e_mul) begin
          e_busy = 1; e_el = 0; p_mul = cm; p_cd = cc; p_pd = cp;
        end else begin
          e_haz = (cc != e_cd && cc != cp) ? 1 : 0;
          e_cd = cc; e_pd = cp;
        end
      end else if (wr_sel == 2'b01) begin
        e_cval = int'(wr_data[7:0]);
        e_psc  = int'(wr_data[10:8]);
      end
    end
    if (wr_en && wr_sel == 2'b10 && wr_data[0]) e_err = 0;
  endtask

  task automatic compare_all();
    int gate, cnt_exp;
    gate    = (e_busy != 0 && (clk_mode <= 2 || clk_mode == 7)) ? 0 : 1;
    cnt_exp = (e_busy != 0) ? (e_cval + e_el / (2 ** (e_psc + 1))) % 256 : e_cval;
    chk("R5 mul_code",    int'(mul_code),    e_mul);
    chk("R7 core_div",    int'(core_div),    e_cd);
    chk("R7 per_div",     int'(per_div),     e_pd);
    chk("R3 busy",        int'(busy),        e_busy);
    chk("R3 core_stall",  int'(core_stall),  e_busy);
    chk("R3 cnt_running", int'(cnt_running), e_busy);
    chk("R2 settle_cnt",  int'(settle_cnt),  cnt_exp);
    chk("R4 core_clk_en", int'(core_clk_en), gate);
    chk("R4 per_clk_en",  int'(per_clk_en),  gate);
    chk("R9 cfg_err",     int'(cfg_err),     e_err);
    chk("R11 hazard",     int'(hazard),      e_haz);
  endtask

  task automatic step(bit we, logic [1:0] sel, logic [15:0] data);
    wr_en = we; wr_sel = sel; wr_data = data;
    @(posedge clk);
    #1;
    model_step();
    compare_all();
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'b00, 16'h0);
  endtask

  function automatic logic [15:0] ratio(int m, int c, int p);
    return 16'((m << 6) | (p << 3) | c);
  endfunction

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_mode = 3'd0; wr_en = 1'b0; wr_sel = 2'b00; wr_data = 16'h0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 mul", int'(mul_code), 0);
    chk("R1 core_div", int'(core_div), 0);
    chk("R1 per_div", int'(per_div), 2);
    chk("R1 busy", int'(busy), 0);
    chk("R1 gates", int'(core_clk_en & per_clk_en), 1);
    chk("R1 cnt", int'(settle_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R2 preload 0xFC, prescale 0 (divide by 2)
    step(1'b1, 2'b01, 16'h00FC);
    chk("R2 preload", int'(settle_cnt), 8'hFC);
    chk("R2 not running", int'(cnt_running), 0);

    // R3/R4 multiplier change in gated mode 0
    step(1'b1, 2'b00, ratio(1, 1, 2));
    chk("R3 busy start", int'(busy), 1);
    idle(2);
    chk("R6 mul held", int'(mul_code), 0);
    // R8 writes during the wait are dropped
    step(1'b1, 2'b00, ratio(3, 4, 4));
    step(1'b1, 2'b01, 16'h0010);
    idle(6);
    chk("R5 released", int'(busy), 0);
    chk("R8 mul applied", int'(mul_code), 1);
    chk("R8 cdiv applied", int'(core_div), 1);
    chk("R5 cnt wrapped", int'(settle_cnt), 0);

    // R7 divider-only change, no hazard (core equals peripheral)
    step(1'b1, 2'b00, ratio(1, 3, 3));
    chk("R7 cdiv now", int'(core_div), 3);
    chk("R7 no start", int'(cnt_running), 0);
    // R11 hazard
    step(1'b1, 2'b00, ratio(1, 2, 3));
    chk("R11 hazard pulse", int'(hazard), 1);
    idle(1);
    chk("R11 hazard drops", int'(hazard), 0);

    // R9 illegal codes
    step(1'b1, 2'b00, ratio(1, 7, 1));
    chk("R9 cdiv kept", int'(core_div), 2);
    chk("R9 err set", int'(cfg_err), 1);
    step(1'b1, 2'b00, ratio(2, 0, 1));
    chk("R9 mul kept", int'(mul_code), 1);
    // R10 error clear
    step(1'b1, 2'b10, 16'h0000);
    chk("R10 zero no effect", int'(cfg_err), 1);
    step(1'b1, 2'b10, 16'h0001);
    chk("R10 cleared", int'(cfg_err), 0);

    // R4 ungated mode 4, preload 0xFE, prescale 2 (divide by 8)
    clk_mode = 3'd4;
    step(1'b1, 2'b01, 16'h02FE);
    step(1'b1, 2'b00, ratio(3, 0, 0));
    chk("R4 ungated", int'(core_clk_en), 1);
    idle(20);

    // gated mode 7, preload 0xFF, prescale 0
    clk_mode = 3'd7;
    step(1'b1, 2'b01, 16'h00FF);
    step(1'b1, 2'b00, ratio(0, 1, 4));
    chk("R4 gated mode 7", int'(per_clk_en), 0);
    idle(4);
    chk("R5 mode 7 applied", int'(per_div), 4);

    // full-length wait from preload 0, prescale 0
    step(1'b1, 2'b00, ratio(1, 0, 2));
    idle(520);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule